// File: doc/BRIEF.md
# Cascaded Clock-Enable Divider Tree

This block derives four related clock rates from one selectable source. Each rate is a single-cycle enable pulse on a fast reference clock. The source is either a slow on-chip oscillator or a fast PLL. The four stages are CPU, MEM, SYS and APB, and they are chained: each stage divides the pulse train of the stage before it. The CPU stage divides by an integer plus a fraction, numerator over denominator. The other three stages divide by whole numbers.

Software writes divider values into shadow registers. These values do nothing until a single-cycle update strobe arrives. After the strobe, each stage copies its shadow into its active register at the next boundary of its own output period. The source selection is different: it is not shadowed and takes effect on the cycle after it is written. A combinational checker compares the active settings and the current source rate against two limits, MEM at most 200 MHz and APB at most 100 MHz, and raises a violation flag when either is broken.

Top module: `clk_tree_div`

## Requirements
- R1: After reset every divider is 1, the fraction is off and the oscillator is selected. All four enables then pulse together once every OSC_DIV reference cycles, and `viol` is low.
- R2: The divider shadows are written through `wr_en`/`wr_addr`/`wr_data` at these addresses: 0 CPU integer, 1 CPU numerator, 2 CPU denominator, 3 MEM, 4 SYS, 5 APB. A write changes no output period until `upd` is pulsed.
- R3: A write to address 6 sets the source from `wr_data[0]` (1 = PLL, which gives one source tick per reference cycle; 0 = oscillator). It takes effect on the next cycle, with no strobe needed.
- R4: With the fraction off, the output periods in source ticks are: CPU = c, MEM = c·m, SYS = c·m·s and APB = c·m·s·a.
- R5: When 0 < numerator < denominator, any denominator consecutive CPU periods total integer·denominator + numerator source ticks. Each period lasts either integer or integer+1 ticks.
- R6: A divider value of 0 behaves as 1.
- R7: `viol` is high exactly when src·D > 200·(I·D+N)·m or src·D > 100·(I·D+N)·m·s·a. Here src is PLL_MHZ or OSC_MHZ, and D=1, N=0 while the fraction is off. This includes fractional settings.
- R8: With the 360 MHz PLL, the settings CPU/MEM/SYS/APB = 1/2/1/2, 2/1/1/2 and 4/1/1/1 keep `viol` low.
- R9: One `upd` pulse commits all stages. Each active register changes only at a pulse of its own stage's enable.
- R10: A MEM pulse only occurs together with a CPU pulse, a SYS pulse only with a MEM pulse, and an APB pulse only with a SYS pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DW | Register write data |
| upd | input | 1 | Single-cycle commit strobe for all divider shadows |
| cpu_en | output | 1 | CPU rate enable pulse |
| mem_en | output | 1 | MEM rate enable pulse |
| sys_en | output | 1 | SYS rate enable pulse |
| apb_en | output | 1 | APB rate enable pulse |
| viol | output | 1 | Active settings exceed a frequency limit |

## Verification
A stage whose active register is wrong shows up as a wrong spacing of its own enable pulses, and of every stage below it. This is visible within one output period after the stage's boundary following `upd`. A stuck pending flag shows up as an old period that persists after the strobe. A fault in the fraction accumulator changes the total length of a run of CPU periods, so that fault is caught within one denominator's worth of CPU periods. The violation flag is combinational on the active state and the source select, so a wrong limit product shows on `viol` in the same cycle the settings become active.

// File: rtl/clk_tree_div.sv
module clk_tree_div #(
  parameter int DW          = 8,
  parameter int OSC_DIV     = 18,
  parameter int PLL_MHZ     = 360,
  parameter int OSC_MHZ     = 20,
  parameter int MEM_MAX_MHZ = 200,
  parameter int APB_MAX_MHZ = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          upd,
  output logic          cpu_en,
  output logic          mem_en,
  output logic          sys_en,
  output logic          apb_en,
  output logic          viol
);
  localparam int OW = $clog2(OSC_DIV + 1);

  function automatic logic [DW-1:0] nz(input logic [DW-1:0] v);
    return (v == '0) ? DW'(1) : v;
  endfunction

  logic          src_q, src_tick;
  logic [OW-1:0] osc_cnt;
  logic [DW-1:0] sh_int, sh_num, sh_den, act_int, act_num, act_den;
  logic [DW-1:0] sh_div [1:3];
  logic [DW-1:0] act_div [1:3];
  logic [DW-1:0] cnt [1:3];
  logic [DW-1:0] ccnt, acc;
  logic          ext, frac_on, cpu_fire;
  logic [DW:0]   len, sum;
  logic [3:0]    pend, en;

  always_ff @(posedge clk) begin
    if (!rst_n) osc_cnt <= '0;
    else if (osc_cnt == OW'(OSC_DIV - 1)) osc_cnt <= '0;
    else osc_cnt <= osc_cnt + 1'b1;
  end
  assign src_tick = src_q | (osc_cnt == OW'(OSC_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      sh_int <= DW'(1);
      sh_num <= '0;
      sh_den <= '0;
      for (int i = 1; i <= 3; i++) sh_div[i] <= DW'(1);
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: sh_int    <= wr_data;
        3'd1: sh_num    <= wr_data;
        3'd2: sh_den    <= wr_data;
        3'd3: sh_div[1] <= wr_data;
        3'd4: sh_div[2] <= wr_data;
        3'd5: sh_div[3] <= wr_data;
        3'd6: src_q     <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else if (upd) pend <= '1;
    else pend <= pend & ~en;
  end

  assign frac_on  = (act_num != '0) && (act_den != '0) && (act_num < act_den);
  assign len      = {1'b0, nz(act_int)} + {{DW{1'b0}}, ext};
  assign sum      = {1'b0, acc} + {1'b0, act_num};
  assign cpu_fire = src_tick && ({1'b0, ccnt} == len - 1'b1);
  assign en[0]    = cpu_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccnt <= '0; acc <= '0; ext <= 1'b0;
      act_int <= DW'(1); act_num <= '0; act_den <= '0;
    end else if (src_tick) begin
      if (cpu_fire) begin
        ccnt <= '0;
        if (pend[0]) begin
          act_int <= sh_int; act_num <= sh_num; act_den <= sh_den;
          acc <= '0; ext <= 1'b0;
        end else if (frac_on) begin
          if (sum >= {1'b0, act_den}) begin
            acc <= DW'(sum - {1'b0, act_den}); ext <= 1'b1;
          end else begin
            acc <= DW'(sum); ext <= 1'b0;
          end
        end else ext <= 1'b0;
      end else ccnt <= ccnt + 1'b1;
    end
  end

  for (genvar k = 1; k <= 3; k++) begin : g_stage
    assign en[k] = en[k-1] && (cnt[k] == nz(act_div[k]) - 1'b1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[k] <= '0; act_div[k] <= DW'(1);
      end else if (en[k-1]) begin
        if (en[k]) begin
          cnt[k] <= '0;
          if (pend[k]) act_div[k] <= sh_div[k];
        end else cnt[k] <= cnt[k] + 1'b1;
      end
    end

    a_r10_nested: assert property (@(posedge clk) disable iff (!rst_n) en[k] |-> en[k-1]);
    a_r9_stage_load: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_div[k]) |-> $past(pend[k] && en[k]));
  end

  assign {apb_en, sys_en, mem_en, cpu_en} = en;

  logic [63:0] smhz, dd, nn, per, lhs;
  always_comb begin
    smhz = src_q ? 64'(PLL_MHZ) : 64'(OSC_MHZ);
    dd   = frac_on ? 64'(act_den) : 64'd1;
    nn   = frac_on ? 64'(act_num) : 64'd0;
    per  = 64'(nz(act_int)) * dd + nn;
    lhs  = smhz * dd;
    viol = (lhs > 64'(MEM_MAX_MHZ) * per * 64'(nz(act_div[1]))) ||
           (lhs > 64'(APB_MAX_MHZ) * per * 64'(nz(act_div[1])) *
                  64'(nz(act_div[2])) * 64'(nz(act_div[3])));
  end

  a_r2_cpu_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_int) |-> $past(pend[0] && cpu_fire));
  a_r3_src_now: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd6) |=> src_q == $past(wr_data[0]));
  a_r7_osc_safe: assert property (@(posedge clk) disable iff (!rst_n)
    !src_q |-> !viol);
endmodule

// File: tb/clk_tree_div_tb_top.sv
module clk_tree_div_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, upd = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic cpu_en, mem_en, sys_en, apb_en, viol;
  logic [3:0] ens;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  clk_tree_div dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .upd(upd), .cpu_en(cpu_en), .mem_en(mem_en),
    .sys_en(sys_en), .apb_en(apb_en), .viol(viol));

  assign ens = {apb_en, sys_en, mem_en, cpu_en};

  localparam int VEC [8][5] = '{
    '{1,2,1,2,0}, '{2,1,1,2,0}, '{4,1,1,1,0}, '{1,1,1,1,1},
    '{1,2,1,1,1}, '{2,1,1,1,1}, '{3,1,2,1,0}, '{1,1,2,2,1}};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  task automatic meas(input int k, input int n, output int p);
    int g = 0;
    @(negedge clk);
    while (!ens[k] && g < 3000) begin @(negedge clk); g++; end
    p = 0;
    for (int i = 0; i < n; i++) begin
      do begin @(negedge clk); p++; end while (!ens[k] && p < 3000);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 viol", int'(viol), 0);
    meas(0, 1, p); chk("R1 cpu period", p, 18);
    meas(3, 1, p); chk("R1 apb period", p, 18);
    // R2 shadow write without strobe
    wr(0, 3); wr(3, 2);
    settle(60);
    meas(0, 1, p); chk("R2 cpu period held", p, 18);
    meas(1, 1, p); chk("R2 mem period held", p, 18);
    // R3 source switch immediate
    wr(6, 1);
    meas(0, 1, p); chk("R3 cpu on pll", p, 1);
    wr(3, 1);
    // R4 R8 R9 R7 table
    for (int v = 0; v < 8; v++) begin
      int c, m, s, a;
      c = VEC[v][0]; m = VEC[v][1]; s = VEC[v][2]; a = VEC[v][3];
      wr(0, c); wr(3, m); wr(4, s); wr(5, a);
      pulse_upd();
      settle(200);
      meas(0, 1, p); chk("R4 cpu period", p, c);
      meas(1, 1, p); chk("R4 mem period", p, c*m);
      meas(2, 1, p); chk("R4 sys period", p, c*m*s);
      meas(3, 1, p); chk("R9 apb period", p, c*m*s*a);
      if (VEC[v][4] == 0) chk("R8 legal no viol", int'(viol), 0);
      else chk("R7 limit viol", int'(viol), 1);
    end
    // R5 fractional 2 + 1/3
    wr(0, 2); wr(1, 1); wr(2, 3); wr(3, 1); wr(4, 1); wr(5, 1);
    pulse_upd();
    settle(100);
    meas(0, 3, p); chk("R5 three cpu periods", p, 7);
    meas(0, 6, p); chk("R5 six cpu periods", p, 14);
    chk("R7 fractional apb viol", int'(viol), 1);
    // R6 zero as one
    wr(1, 0); wr(3, 0); wr(5, 4);
    pulse_upd();
    settle(100);
    meas(1, 1, p); chk("R6 mem zero div", p, 2);
    chk("R7 no viol at 180/45", int'(viol), 0);
    wr(0, 0); wr(5, 0);
    pulse_upd();
    settle(100);
    meas(0, 1, p); chk("R6 cpu zero div", p, 1);
    chk("R7 viol all ones", int'(viol), 1);
    // R3 back to oscillator
    wr(6, 0);
    chk("R3 osc viol clear", int'(viol), 0);
    meas(3, 1, p); chk("R3 apb on osc", p, 18);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule